// File: doc/BRIEF.md
# Up-Counting Timer with Shadowed Reload

This block is a 16-bit up-counter clocked through a 16-bit prescaler. The counter runs from zero to an active reload limit, wraps to zero and raises an overflow update event. The prescaler ratio always passes through a shadow register. The reload limit goes through a shadow register only when preload buffering is switched on. Both shadows are copied into their active registers on an update event.

Software drives the block through a small word-addressed register interface with a combinational read path. Update events can come from counter overflow or from a software update command. Update events can be suppressed as a whole, or kept from raising the status flag. A one-pulse mode makes the counter stop itself at the next update event. The status flag can be mirrored into bit 31 of the counter readback.

There are three outputs. An interrupt level, a one-cycle DMA request pulse, and a registered trigger output for chaining timers. The trigger output can carry one of three sources.

Top module: `preloadTimer`

## Requirements
- R1: After reset every register reads zero, and irqOut, dmaReq and trigOut are low. The offsets are 0x00 control A, 0x04 control B, 0x0C enable, 0x10 status, 0x14 command, 0x24 count, 0x28 prescale and 0x2C reload.
- R2: While control A bit 0 (run) is set, the prescale counter advances on every clock. The count value advances once per (active prescale + 1) clocks. When the count has reached the active reload limit, the next advance sets it to 0 and raises an overflow.
- R3: An overflow that is not suppressed sets status bit 0 (update flag).
- R4: Writing 1 to command bit 0 clears the count and the prescale counter. It raises an update event unless control A bit 1 is set. The command register reads as 0.
- R5: With control A bit 2 at 0, a software update also sets the update flag. With it at 1, only overflow sets the flag.
- R6: With control A bit 1 (update suppress) set, no update event occurs and the active prescale value keeps its value. A software update still clears the count.
- R7: With control A bit 7 at 0, a reload write takes effect at once. With it at 1, the written value waits in a buffer until the next update event, and reads of 0x2C return the buffered value.
- R8: With control A bit 3 (single shot) set, the run bit is cleared by hardware on the update event.
- R9: A status write clears only the bits written as 0. A 1 written to a bit has no effect.
- R10: With control A bit 11 set, count readback bit 31 returns the update flag. With it clear, bit 31 reads 0. The count occupies bits 15:0.
- R11: irqOut is the update flag gated by enable bit 0. dmaReq is a one-cycle pulse, one clock after each flag-setting event, when enable bit 8 is set.
- R12: trigOut is registered and selected by control B bits 6:4. Code 0 gives the command pulse, code 1 gives the run bit and code 2 gives the update event pulse, each one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe |
| busAddr | input | 6 | Byte address of register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data at busAddr |
| irqOut | output | 1 | Update interrupt level |
| dmaReq | output | 1 | Update DMA request pulse |
| trigOut | output | 1 | Trigger output for chaining |

## Verification
A software update command can arrive in the same cycle as a counter overflow. The overflow is dropped because the clear takes priority. The flag-setting rules then decide whether the command alone sets the update flag, and this is judged through status readback under both settings of the request-source bit. A hardware clear of the run bit by single-shot mode can also coincide with a write to control A. The bench provokes the single-shot stop by letting the count reach its limit, then reads control A to confirm that the run bit has fallen and the count stays at zero.

// File: rtl/timerPkg.sv
package timerPkg;
  localparam int unsigned DATA_W = 32;

  localparam logic [5:0] OFS_CTRLA  = 6'h00;
  localparam logic [5:0] OFS_CTRLB  = 6'h04;
  localparam logic [5:0] OFS_ENABLE = 6'h0C;
  localparam logic [5:0] OFS_STATUS = 6'h10;
  localparam logic [5:0] OFS_CMD    = 6'h14;
  localparam logic [5:0] OFS_COUNT  = 6'h24;
  localparam logic [5:0] OFS_PSCL   = 6'h28;
  localparam logic [5:0] OFS_RELOAD = 6'h2C;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic loadCnt;
    logic runEn;
  } coreCtl_t;
endpackage

// File: rtl/timerCore.sv
module timerCore
  import timerPkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  coreCtl_t         ctl,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] pscLimit,
  input  logic [CNT_W-1:0] arrLimit,
  output logic [CNT_W-1:0] countOut,
  output logic             overflow
);
  logic [CNT_W-1:0] pscCnt;
  logic [CNT_W-1:0] cnt;
  logic pscHit, tick, atLimit;

  assign pscHit  = pscCnt >= pscLimit;
  assign tick    = ctl.runEn & pscHit;
  assign atLimit = cnt >= arrLimit;
  assign overflow = tick & atLimit & ~ctl.clearAll & ~ctl.loadCnt;
  assign countOut = cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pscCnt <= '0;
      cnt    <= '0;
    end else if (ctl.clearAll) begin
      pscCnt <= '0;
      cnt    <= '0;
    end else begin
      if (ctl.runEn) pscCnt <= pscHit ? '0 : pscCnt + 1'b1;
      if (ctl.loadCnt) cnt <= loadVal;
      else if (tick) cnt <= atLimit ? '0 : cnt + 1'b1;
    end
  end

  assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> (cnt == '0));
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.runEn && !ctl.clearAll && !ctl.loadCnt) |=> $stable(cnt));
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearAll |=> (cnt == '0 && pscCnt == '0));
endmodule

// File: rtl/timerRegs.sv
module timerRegs
  import timerPkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CNT_W-1:0]  countIn,
  input  logic              overflow,
  output coreCtl_t          ctl,
  output logic [CNT_W-1:0]  loadVal,
  output logic [CNT_W-1:0]  pscLimit,
  output logic [CNT_W-1:0]  arrLimit,
  output logic              irqOut,
  output logic              dmaReq,
  output logic              trigOut
);
  localparam int unsigned PAD_W = DATA_W - 1 - CNT_W;

  logic runBit, updOff, srcOvfOnly, oneShot, arrBuf, flagMirror;
  logic [2:0] trigSel;
  logic irqEn, dmaEn, updFlag;
  logic [CNT_W-1:0] pscPre, pscAct, arrPre, arrAct;
  logic wCtrlA, wCtrlB, wEnable, wStatus, wCmd, wCount, wPscl, wReload;
  logic ugStrobe, uev, flagEvt;

  assign wCtrlA  = busWr && (busAddr == OFS_CTRLA);
  assign wCtrlB  = busWr && (busAddr == OFS_CTRLB);
  assign wEnable = busWr && (busAddr == OFS_ENABLE);
  assign wStatus = busWr && (busAddr == OFS_STATUS);
  assign wCmd    = busWr && (busAddr == OFS_CMD);
  assign wCount  = busWr && (busAddr == OFS_COUNT);
  assign wPscl   = busWr && (busAddr == OFS_PSCL);
  assign wReload = busWr && (busAddr == OFS_RELOAD);

  assign ugStrobe = wCmd & busWdata[0];
  assign uev      = ~updOff & (overflow | ugStrobe);
  assign flagEvt  = ~updOff & (overflow | (ugStrobe & ~srcOvfOnly));

  assign ctl.clearAll = ugStrobe;
  assign ctl.loadCnt  = wCount;
  assign ctl.runEn    = runBit;
  assign loadVal  = busWdata[CNT_W-1:0];
  assign pscLimit = pscAct;
  assign arrLimit = arrAct;
  assign irqOut   = updFlag & irqEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runBit <= 1'b0; updOff <= 1'b0; srcOvfOnly <= 1'b0;
      oneShot <= 1'b0; arrBuf <= 1'b0; flagMirror <= 1'b0;
      trigSel <= '0; irqEn <= 1'b0; dmaEn <= 1'b0; updFlag <= 1'b0;
      pscPre <= '0; pscAct <= '0; arrPre <= '0; arrAct <= '0;
      dmaReq <= 1'b0; trigOut <= 1'b0;
    end else begin
      if (wCtrlA) begin
        runBit     <= busWdata[0];
        updOff     <= busWdata[1];
        srcOvfOnly <= busWdata[2];
        oneShot    <= busWdata[3];
        arrBuf     <= busWdata[7];
        flagMirror <= busWdata[11];
      end
      if (oneShot && uev) runBit <= 1'b0;
      if (wCtrlB) trigSel <= busWdata[6:4];
      if (wEnable) begin
        irqEn <= busWdata[0];
        dmaEn <= busWdata[8];
      end
      if (flagEvt) updFlag <= 1'b1;
      else if (wStatus) updFlag <= updFlag & busWdata[0];
      if (uev) begin
        pscAct <= pscPre;
        arrAct <= arrPre;
      end
      if (wPscl) pscPre <= busWdata[CNT_W-1:0];
      if (wReload) begin
        arrPre <= busWdata[CNT_W-1:0];
        if (!arrBuf) arrAct <= busWdata[CNT_W-1:0];
      end
      dmaReq <= flagEvt & dmaEn;
      case (trigSel)
        3'd0:    trigOut <= ugStrobe;
        3'd1:    trigOut <= runBit;
        3'd2:    trigOut <= uev;
        default: trigOut <= 1'b0;
      endcase
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      OFS_CTRLA:  busRdata = {{(DATA_W-12){1'b0}}, flagMirror, 3'b0, arrBuf,
                              3'b0, oneShot, srcOvfOnly, updOff, runBit};
      OFS_CTRLB:  busRdata = {{(DATA_W-7){1'b0}}, trigSel, 4'b0};
      OFS_ENABLE: busRdata = {{(DATA_W-9){1'b0}}, dmaEn, 7'b0, irqEn};
      OFS_STATUS: busRdata = {{(DATA_W-1){1'b0}}, updFlag};
      OFS_COUNT:  busRdata = {flagMirror & updFlag, {PAD_W{1'b0}}, countIn};
      OFS_PSCL:   busRdata = {{(DATA_W-CNT_W){1'b0}}, pscPre};
      OFS_RELOAD: busRdata = {{(DATA_W-CNT_W){1'b0}}, arrPre};
      default:    busRdata = '0;
    endcase
  end

  assert_oneshot_stop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (oneShot && uev) |=> !runBit);
  assert_suppress_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    updOff |=> $stable(pscAct));
  assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    flagEvt |=> updFlag);
  assert_dma_gate_R11: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> $past(dmaEn));
  assert_buffer_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (arrBuf && !uev) |=> $stable(arrAct));
endmodule

// File: rtl/preloadTimer.sv
module preloadTimer
  import timerPkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irqOut,
  output logic              dmaReq,
  output logic              trigOut
);
  coreCtl_t ctl;
  logic [CNT_W-1:0] loadVal, pscLimit, arrLimit, countVal;
  logic overflow;

  timerRegs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .countIn(countVal),
    .overflow(overflow), .ctl(ctl), .loadVal(loadVal), .pscLimit(pscLimit),
    .arrLimit(arrLimit), .irqOut(irqOut), .dmaReq(dmaReq), .trigOut(trigOut)
  );

  timerCore #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rstN(rstN), .ctl(ctl), .loadVal(loadVal),
    .pscLimit(pscLimit), .arrLimit(arrLimit), .countOut(countVal),
    .overflow(overflow)
  );
endmodule

// File: tb/preloadTimer_bench.sv
module preloadTimer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0;
  logic [5:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic irqOut, dmaReq, trigOut;
  int errors = 0;
  int checks = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  preloadTimer u_preloadTimer (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut),
    .dmaReq(dmaReq), .trigOut(trigOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    busAddr = a; #1;
    d = busRdata;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] expCount(input int m, input int p, input int a);
    return 32'((m / (p + 1)) % (a + 1));
  endfunction

  function automatic logic [31:0] expFlag(input int m, input int p, input int a);
    return ((m / (p + 1)) >= (a + 1)) ? 32'd1 : 32'd0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    foreach (timerPkg::OFS_CTRLA[i]) ; // no-op placeholder-free loop guard
    begin
      logic [5:0] offs [8] = '{6'h00, 6'h04, 6'h0C, 6'h10, 6'h14, 6'h24, 6'h28, 6'h2C};
      for (int i = 0; i < 8; i++) begin
        rd(offs[i], rv); check("R1 reset reg", rv, 32'd0);
      end
    end
    check("R1 irq", {31'd0, irqOut}, 0);
    check("R1 dma", {31'd0, dmaReq}, 0);
    check("R1 trig", {31'd0, trigOut}, 0);

    // R2 / R3 random rate and overflow flag
    for (int t = 0; t < 10; t++) begin
      int p, a, m;
      p = $urandom % 4; a = $urandom % 8; m = $urandom % 60;
      wr(6'h00, 0); wr(6'h28, p); wr(6'h2C, a); wr(6'h14, 1); wr(6'h10, 0);
      wr(6'h00, 1);
      waitEdges(m);
      rd(6'h24, rv); check("R2 count", rv, expCount(m, p, a));
      rd(6'h10, rv); check("R3 flag", rv, expFlag(m, p, a));
    end

    // R6 update suppress
    wr(6'h00, 0); wr(6'h28, 0); wr(6'h2C, 100); wr(6'h14, 1); wr(6'h10, 0);
    wr(6'h00, 2); wr(6'h28, 3); wr(6'h24, 9);
    rd(6'h24, rv); check("R6 count load", rv, 9);
    wr(6'h14, 1);
    rd(6'h24, rv); check("R6 cmd clears count", rv, 0);
    rd(6'h10, rv); check("R6 no flag", rv, 0);
    wr(6'h00, 3); waitEdges(8);
    rd(6'h24, rv); check("R6 prescale held", rv, 8);

    // R5 request source, R4 command readback
    wr(6'h00, 4); wr(6'h14, 1);
    rd(6'h10, rv); check("R5 overflow-only no flag", rv, 0);
    rd(6'h14, rv); check("R4 cmd reads zero", rv, 0);
    wr(6'h00, 0); wr(6'h14, 1);
    rd(6'h10, rv); check("R5 cmd sets flag", rv, 1);
    // R9 status clear by zero
    wr(6'h10, 1); rd(6'h10, rv); check("R9 write one keeps", rv, 1);
    wr(6'h10, 0); rd(6'h10, rv); check("R9 write zero clears", rv, 0);

    // R10 mirror
    wr(6'h14, 1); wr(6'h00, 32'h800);
    rd(6'h24, rv); check("R10 mirror on", rv, 32'h8000_0000);
    wr(6'h00, 0);
    rd(6'h24, rv); check("R10 mirror off", rv, 0);

    // R11 interrupt and DMA
    wr(6'h0C, 1); check("R11 irq high", {31'd0, irqOut}, 1);
    wr(6'h10, 0); check("R11 irq low", {31'd0, irqOut}, 0);
    wr(6'h0C, 32'h100); wr(6'h14, 1);
    check("R11 dma pulse", {31'd0, dmaReq}, 1);
    waitEdges(1); check("R11 dma one cycle", {31'd0, dmaReq}, 0);

    // R12 trigger select
    wr(6'h04, 0); wr(6'h14, 1);
    check("R12 cmd source", {31'd0, trigOut}, 1);
    wr(6'h04, 32'h10); wr(6'h00, 1); waitEdges(1);
    check("R12 run source", {31'd0, trigOut}, 1);
    wr(6'h00, 0); waitEdges(1);
    check("R12 run source low", {31'd0, trigOut}, 0);
    wr(6'h04, 32'h20); wr(6'h14, 1);
    check("R12 update source", {31'd0, trigOut}, 1);
    waitEdges(1); check("R12 update pulse ends", {31'd0, trigOut}, 0);

    // R7 reload buffering
    wr(6'h00, 32'h80); wr(6'h28, 0); wr(6'h2C, 7); wr(6'h14, 1);
    wr(6'h2C, 3);
    rd(6'h2C, rv); check("R7 buffered readback", rv, 3);
    wr(6'h00, 32'h81); waitEdges(4);
    rd(6'h24, rv); check("R7 old limit active", rv, 4);
    waitEdges(10);
    rd(6'h24, rv); check("R7 new limit after update", rv, 2);

    // R8 single shot
    wr(6'h00, 32'h08); wr(6'h2C, 3); wr(6'h14, 1); wr(6'h10, 0);
    wr(6'h00, 32'h09); waitEdges(12);
    rd(6'h24, rv); check("R8 count stopped", rv, 0);
    rd(6'h00, rv); check("R8 run cleared", rv & 32'h1, 0);
    rd(6'h10, rv); check("R8 flag set", rv, 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule